// File: doc/BRIEF.md
# Agree-Style Conditional Branch Direction Predictor

This block gives the fetch stage a taken or not-taken guess for a conditional branch. Fetch presents a virtual address and, in the same cycle, gets back a prediction. It also gets back the two table indices that produced the guess and the bias bit that was read. The pipeline carries these values along with the branch. When the branch resolves, they return on the resolve port together with the real outcome, so that training lands on the same entries.

The predictor has two tables. The first is a table of 2-bit saturating counters, indexed by the global outcome history. These counters do not predict a direction. They predict whether the branch will follow a one-bit bias held in the second table. The bias table is indexed by the fetch address bits XORed with the history. Neither table carries tags, so unrelated branches can share entries, and this is intended. A bias bit changes only after its counter has fully lost confidence.

A flush input returns every entry and the history to their initial values in a single cycle. This is done by clearing per-entry valid bits rather than rewriting the storage.

Top module: `bp_agree`

## Requirements
- R1: After reset, each counter reads as weak-agree (2), each bias bit reads as 0 and the history is 0, so every prediction is not-taken with `predPatIdx` equal to 0.
- R2: `predPatIdx` equals the history register. `predBiasIdx` equals `fetchAddr[IDX_LSB +: IDX_W]` XOR the history.
- R3: `predTaken` equals the bias bit read when the selected counter is 2 or 3. It equals the inverted bias bit when the counter is 0 or 1. `predBias` reports the bias bit that was read.
- R4: When a resolve outcome equals the returned bias bit, the counter at `resPatIdx` increments and holds at 3.
- R5: When a resolve outcome differs from the returned bias bit and the counter is above 0, the counter decrements. When the counter is already 0, the bias bit at `resBiasIdx` toggles and the counter becomes 2 in the same cycle.
- R6: From a counter value of 3, the first disagreeing outcome leaves the prediction unchanged and the second one inverts it.
- R7: Each resolve shifts the history left by one, with the outcome entering at bit 0. Without a resolve, the history holds.
- R8: A flush restores the R1 state at the next edge. A resolve in the same cycle as a flush has no effect.
- R9: When a resolve and a prediction select the same entries in one cycle, the prediction shows the values from before the update.
- R10: Two fetch addresses that differ only above the index bits, seen with the same history, share entries. Training through one changes the prediction for the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clears all predictor state in one cycle |
| fetchAddr | input | ADDR_W | Fetch virtual address |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| predPatIdx | output | IDX_W | Counter table index used |
| predBiasIdx | output | IDX_W | Bias table index used |
| predBias | output | 1 | Bias bit read for this prediction |
| resValid | input | 1 | A resolved branch is presented |
| resTaken | input | 1 | Actual outcome, 1 = taken |
| resPatIdx | input | IDX_W | Counter index saved at prediction |
| resBiasIdx | input | IDX_W | Bias index saved at prediction |
| resBias | input | 1 | Bias bit saved at prediction |

## Verification
The hardest state to reach from the ports is a bias toggle. It needs the same counter to be driven down to 0 by disagreements. However, every resolve also changes the history, which is that counter's index. The stimulus therefore repeats one branch at one address with the same outcome. This fills the history with ones, so the counter index and the bias index stay fixed. Repeated taken outcomes against a zero bias then walk the counter to 0, toggle the bias, and train it back up. Opposing outcomes after that exercise the two-step flip from the strong state.

// File: rtl/bp_agree_pkg.sv
package bp_agree_pkg;

  localparam logic [1:0] CNT_MIN        = 2'd0;
  localparam logic [1:0] CNT_MAX        = 2'd3;
  localparam logic [1:0] CNT_WEAK_AGREE = 2'd2;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic clearAll;
    logic histShift;
    logic cntInc;
    logic cntDec;
    logic cntSetWeak;
    logic biasToggle;
  } bpStrobe_t;

endpackage

// File: rtl/bp_agree_ctrl.sv
module bp_agree_ctrl
  import bp_agree_pkg::*;
(
  input  logic       flush,
  input  logic       resValid,
  input  logic       resTaken,
  input  logic       resBias,
  input  logic [1:0] resCnt,
  output bpStrobe_t  stb
);

  logic agree;

  assign agree = (resTaken == resBias);

  always_comb begin
    stb = '0;
    if (flush) begin
      stb.clearAll = 1'b1;
    end else if (resValid) begin
      stb.histShift = 1'b1;
      if (agree) begin
        stb.cntInc = (resCnt != CNT_MAX);
      end else if (resCnt == CNT_MIN) begin
        stb.biasToggle = 1'b1;
        stb.cntSetWeak = 1'b1;
      end else begin
        stb.cntDec = 1'b1;
      end
    end
  end

endmodule

// File: rtl/bp_agree_data.sv
module bp_agree_data
  import bp_agree_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 6,
  parameter int IDX_LSB = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  bpStrobe_t         stb,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [IDX_W-1:0]  resPatIdx,
  input  logic [IDX_W-1:0]  resBiasIdx,
  input  logic              resTaken,
  output logic [IDX_W-1:0]  predPatIdx,
  output logic [IDX_W-1:0]  predBiasIdx,
  output logic [1:0]        predCnt,
  output logic              predBias,
  output logic [1:0]        resCnt
);

  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0] hist;
  logic [1:0]       cntEff  [DEPTH];
  logic             biasEff [DEPTH];
  logic [1:0]       cntNext;
  logic             biasNext;
  logic             cntWrAny;

  // Global outcome history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              hist <= '0;
    else if (stb.clearAll)  hist <= '0;
    else if (stb.histShift) hist <= {hist[IDX_W-2:0], resTaken};
  end

  assign cntWrAny = stb.cntInc | stb.cntDec | stb.cntSetWeak;

  always_comb begin
    cntNext = resCnt;
    if (stb.cntSetWeak)  cntNext = CNT_WEAK_AGREE;
    else if (stb.cntInc) cntNext = resCnt + 2'd1;
    else if (stb.cntDec) cntNext = resCnt - 2'd1;
  end

  assign biasNext = ~biasEff[resBiasIdx];

  // One storage slot per index in each table, each with a valid bit
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic [1:0] cntQ;
    logic       cntVld;
    logic       biasQ;
    logic       biasVld;
    logic       cntWr;
    logic       biasWr;

    assign cntWr  = cntWrAny && (resPatIdx == IDX_W'(e));
    assign biasWr = stb.biasToggle && (resBiasIdx == IDX_W'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntVld  <= 1'b0;
        biasVld <= 1'b0;
      end else if (stb.clearAll) begin
        cntVld  <= 1'b0;
        biasVld <= 1'b0;
      end else begin
        if (cntWr)  cntVld  <= 1'b1;
        if (biasWr) biasVld <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (cntWr)  cntQ  <= cntNext;
      if (biasWr) biasQ <= biasNext;
    end

    assign cntEff[e]  = cntVld  ? cntQ  : CNT_WEAK_AGREE;
    assign biasEff[e] = biasVld ? biasQ : 1'b0;
  end

  assign predPatIdx  = hist;
  assign predBiasIdx = fetchAddr[IDX_LSB +: IDX_W] ^ hist;
  assign predCnt     = cntEff[predPatIdx];
  assign predBias    = biasEff[predBiasIdx];
  assign resCnt      = cntEff[resPatIdx];

endmodule

// File: rtl/bp_agree.sv
module bp_agree
  import bp_agree_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 6,
  parameter int IDX_LSB = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              predTaken,
  output logic [IDX_W-1:0]  predPatIdx,
  output logic [IDX_W-1:0]  predBiasIdx,
  output logic              predBias,
  input  logic              resValid,
  input  logic              resTaken,
  input  logic [IDX_W-1:0]  resPatIdx,
  input  logic [IDX_W-1:0]  resBiasIdx,
  input  logic              resBias
);

  bpStrobe_t  stb;
  logic [1:0] predCnt;
  logic [1:0] resCnt;

  bp_agree_ctrl i_ctrl (
    .flush    (flush),
    .resValid (resValid),
    .resTaken (resTaken),
    .resBias  (resBias),
    .resCnt   (resCnt),
    .stb      (stb)
  );

  bp_agree_data #(
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .IDX_LSB (IDX_LSB)
  ) i_data (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .fetchAddr   (fetchAddr),
    .resPatIdx   (resPatIdx),
    .resBiasIdx  (resBiasIdx),
    .resTaken    (resTaken),
    .predPatIdx  (predPatIdx),
    .predBiasIdx (predBiasIdx),
    .predCnt     (predCnt),
    .predBias    (predBias),
    .resCnt      (resCnt)
  );

  // Counter high bit says "follow the bias"
  assign predTaken = predCnt[1] ? predBias : ~predBias;

endmodule

// File: rtl/bp_agree_chk.sv
module bp_agree_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             flush,
  input logic             resValid,
  input logic             resTaken,
  input logic             predTaken,
  input logic             predBias,
  input logic [IDX_W-1:0] predPatIdx
);

  a_r8_flush_clears_hist: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (predPatIdx == '0));

  a_r8_flush_pred_not_taken: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!predTaken && !predBias));

  a_r7_hist_shift: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !flush) |=>
      (predPatIdx == {$past(predPatIdx[IDX_W-2:0]), $past(resTaken)}));

  a_r7_hist_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!resValid && !flush) |=> $stable(predPatIdx));

endmodule

bind bp_agree bp_agree_chk #(.IDX_W(IDX_W)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .flush      (flush),
  .resValid   (resValid),
  .resTaken   (resTaken),
  .predTaken  (predTaken),
  .predBias   (predBias),
  .predPatIdx (predPatIdx)
);

// File: tb/test_bp_agree.sv
`timescale 1ns/1ps
module test_bp_agree;

  localparam int ADDR_W  = 32;
  localparam int IDX_W   = 6;
  localparam int IDX_LSB = 2;
  localparam int DEPTH   = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              flush = 1'b0;
  logic [ADDR_W-1:0] fetchAddr = '0;
  logic              predTaken;
  logic [IDX_W-1:0]  predPatIdx;
  logic [IDX_W-1:0]  predBiasIdx;
  logic              predBias;
  logic              resValid = 1'b0;
  logic              resTaken = 1'b0;
  logic [IDX_W-1:0]  resPatIdx = '0;
  logic [IDX_W-1:0]  resBiasIdx = '0;
  logic              resBias = 1'b0;

  always #4 clk = ~clk;

  bp_agree #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) i_bp_agree (
    .clk(clk), .rstN(rstN), .flush(flush), .fetchAddr(fetchAddr),
    .predTaken(predTaken), .predPatIdx(predPatIdx), .predBiasIdx(predBiasIdx),
    .predBias(predBias), .resValid(resValid), .resTaken(resTaken),
    .resPatIdx(resPatIdx), .resBiasIdx(resBiasIdx), .resBias(resBias)
  );

  typedef struct {
    logic             taken;
    logic [IDX_W-1:0] pat;
    logic [IDX_W-1:0] bidx;
    logic             bias;
    string            tag;
  } expItem_t;

  expItem_t expQ[$];
  event     evSample;
  int       checks = 0;
  int       errors = 0;
  bit       done = 1'b0;

  // Reference model built from the requirements
  int               mCnt  [DEPTH];
  bit               mBias [DEPTH];
  bit [IDX_W-1:0]   mHist;
  logic [IDX_W-1:0] lastPat;
  logic [IDX_W-1:0] lastBidx;
  logic             lastBias;

  function automatic void mReset();
    for (int i = 0; i < DEPTH; i++) begin
      mCnt[i]  = 2;
      mBias[i] = 1'b0;
    end
    mHist = '0;
  endfunction

  task automatic step(input logic [ADDR_W-1:0] a, input bit rv, input bit rt,
                      input logic [IDX_W-1:0] rp, input logic [IDX_W-1:0] rb,
                      input bit rbias, input bit fl, input string tag);
    expItem_t it;
    @(negedge clk);
    fetchAddr  = a;
    resValid   = rv;
    resTaken   = rt;
    resPatIdx  = rp;
    resBiasIdx = rb;
    resBias    = rbias;
    flush      = fl;
    it.pat   = mHist;
    it.bidx  = a[IDX_LSB +: IDX_W] ^ mHist;
    it.bias  = mBias[it.bidx];
    it.taken = (mCnt[mHist] >= 2) ? it.bias : ~it.bias;
    it.tag   = tag;
    lastPat  = it.pat;
    lastBidx = it.bidx;
    lastBias = it.bias;
    expQ.push_back(it);
    #1;
    -> evSample;
    if (fl) begin
      mReset();
    end else if (rv) begin
      if (rt == rbias) begin
        if (mCnt[rp] < 3) mCnt[rp]++;
      end else if (mCnt[rp] == 0) begin
        mBias[rb] = ~mBias[rb];
        mCnt[rp]  = 2;
      end else begin
        mCnt[rp]--;
      end
      mHist = {mHist[IDX_W-2:0], rt};
    end
  endtask

  // Predict one branch, then resolve it while the same address is fetched again
  task automatic branch(input logic [ADDR_W-1:0] a, input bit t, input string tag);
    logic [IDX_W-1:0] p;
    logic [IDX_W-1:0] b;
    logic             bb;
    step(a, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, tag);
    p = lastPat; b = lastBidx; bb = lastBias;
    step(a, 1'b1, t, p, b, bb, 1'b0, tag);
  endtask

  task automatic idle(input logic [ADDR_W-1:0] a, input string tag);
    step(a, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, tag);
  endtask

  // Monitor: pop expected items and compare with the ports
  initial begin
    expItem_t it;
    forever begin
      @(evSample);
      if (expQ.size() != 0) begin
        it = expQ.pop_front();
        checks++;
        if (predTaken !== it.taken || predPatIdx !== it.pat ||
            predBiasIdx !== it.bidx || predBias !== it.bias) begin
          errors++;
          $display("FAIL %s: taken/pat/bidx/bias actual %0b/%0d/%0d/%0b expected %0b/%0d/%0d/%0b",
                   it.tag, predTaken, predPatIdx, predBiasIdx, predBias,
                   it.taken, it.pat, it.bidx, it.bias);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    mReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state, R2 index forming
    idle(32'h0000_0000, "R1");
    idle(32'h0000_0104, "R1");
    idle(32'h0000_FFFC, "R2");
    idle(32'h1234_5678, "R2");

    // R7 history and R5 toggle: repeated taken fills history with ones,
    // then walks one counter to 0 against bias 0 and flips the bias
    for (int i = 0; i < 8; i++) branch(32'h0000_0040, 1'b1, "R7");
    for (int i = 0; i < 6; i++) branch(32'h0000_0040, 1'b1, "R5");
    // R4 counter climbs to saturation on agreement
    for (int i = 0; i < 4; i++) branch(32'h0000_0040, 1'b1, "R4");
    // R6 two opposing outcomes from the strong state; R9 same-cycle reads
    branch(32'h0000_0040, 1'b0, "R6");
    idle(32'h0000_0040, "R6");
    branch(32'h0000_0040, 1'b1, "R9");
    for (int i = 0; i < 3; i++) branch(32'h0000_0040, 1'b1, "R6");
    branch(32'h0000_0040, 1'b0, "R6");
    branch(32'h0000_0040, 1'b0, "R6");
    // R3 inverted bias when counter low
    for (int i = 0; i < 6; i++) branch(32'h0000_0040, 1'b1, "R3");
    for (int i = 0; i < 3; i++) branch(32'h0000_0040, 1'b0, "R3");

    // R10 aliasing through address bits above the index
    for (int i = 0; i < 4; i++) branch(32'h0000_0140, 1'b1, "R10");
    idle(32'h0000_0040, "R10");
    idle(32'h0000_8040, "R10");

    // R8 flush, and flush with a simultaneous resolve
    step(32'h0000_0040, 1'b0, 1'b0, '0, '0, 1'b0, 1'b1, "R8");
    idle(32'h0000_0040, "R8");
    branch(32'h0000_0080, 1'b0, "R8");
    idle(32'h0000_0080, "R8");
    step(32'h0000_0080, 1'b1, 1'b1, lastPat, lastBidx, lastBias, 1'b1, "R8");
    idle(32'h0000_0080, "R8");
    idle(32'h0000_0040, "R8");

    // R4/R5 mixed traffic with pseudo-random addresses and outcomes
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      branch({20'h0, lfsr[11:0]} & 32'h0000_00FC, lfsr[3] | lfsr[7], "R4");
    end
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      branch({16'h0, lfsr}, lfsr[5], "R5");
    end

    @(negedge clk);
    resValid = 1'b0;
    flush    = 1'b0;
    #2;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule